// File: doc/BRIEF.md
# Serial ADC Sequencer with Shutdown

This block is the master-side controller for a single-channel serial sampling converter that uses an active-low chip select, a serial clock and one returned data line. A one-cycle start request opens a conversion. The controller lowers chip select and toggles the serial clock at a rate set by a divider parameter. It samples the returned line on each rising serial clock edge, because the converter shifts on falling edges. Twelve fixed bit positions of the frame form the sample, and the result appears on a registered output with a one-cycle valid strobe.

The converter wakes from an unknown mode after power-up and from shutdown, so its first conversion after either is not trustworthy. The controller tracks this itself. When the converter may be asleep, a start request first runs a full-length dummy frame whose data is dropped, waits a quiet gap, and only then runs the frame that is reported. If the low-power input is high when a reported frame completes, a short frame follows on its own. That frame releases chip select part-way through, which parks the converter in shutdown until the next request. Every frame is followed by a quiet gap with chip select high.

Top module: `serial_adc_seq`

## Requirements
- R1: During and right after reset, `cs_n_o` is 1, `sclk_o` is 1 and `valid_o` is 0.
- R2: A dummy or reported frame has exactly FRAME_FALLS (16) falling serial clock edges. The serial clock is high whenever chip select is high, and each low phase lasts HALF_DIV system clocks.
- R3: The line is sampled at rising serial clock edges. Rising edges LEAD_BITS+1 through FRAME_FALLS (5 to 16) give the sample MSB first. The first LEAD_BITS (4) sampled bits have no effect on the sample.
- R4: The first start after reset runs a dummy frame and then a reported frame. The dummy frame produces no valid strobe and its data never appears on `sample_o`.
- R5: Between the end of any frame and the start of the next, chip select stays high for at least QUIET_CYC system clocks.
- R6: Each reported frame produces exactly one `valid_o` pulse, one system clock wide, with that frame's sample on `sample_o`.
- R7: If `low_power_i` is 1 when a reported frame ends, a shutdown frame follows without a new request. It has SHUT_FALLS (12, within 11 to 14) falling edges and produces no valid strobe.
- R8: After a shutdown frame, the next start runs a dummy frame before the reported frame.
- R9: With the converter awake and `low_power_i` at 0, a start runs exactly one reported frame and no dummy frame.
- R10: A start request that arrives while a frame sequence is running is ignored. It adds no frame and no valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, one system clock wide |
| low_power_i | input | 1 | Shut the converter down after each reported sample |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idle high |
| sdi_i | input | 1 | Serial data returned by the converter |
| sample_o | output | DATA_W | Last reported sample |
| valid_o | output | 1 | One-cycle strobe for a new reported sample |

## Verification
The bench builds the block with HALF_DIV=2 and QUIET_CYC=5. Frame widths keep their defaults: 16 edges, 12 for shutdown, 4 leading bits. A reported frame then takes about 70 system clocks. That is short enough for a sweep of 24 requests with a repeating low-power pattern, which reaches every wake/sleep transition several times. The converter model in the bench puts a fixed nonzero pattern in the leading positions and gives each frame a different value, including all-zero, all-one, MSB-only and LSB-only values. This makes a stray leading bit, a reported dummy frame or a shifted field visible at the sample output.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    FR_DUMMY = 2'd0,
    FR_REAL  = 2'd1,
    FR_SHUT  = 2'd2
  } frame_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_QUIET = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int DW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] cnt;

  // serial clock idles high; ticks mark the cycle in which sclk has its new level
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt       <= '0;
      sclk      <= 1'b1;
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt       <= '0;
      sclk      <= ~sclk;
      fall_tick <= sclk;
      rise_tick <= ~sclk;
    end else begin
      cnt       <= cnt + 1'b1;
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
  parameter int DATA_W      = 12,
  parameter int LEAD_BITS   = 4,
  parameter int FRAME_FALLS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              rise_tick,
  input  logic              sdi,
  output logic [DATA_W-1:0] data
);
  localparam int RW = $clog2(FRAME_FALLS + 1);
  localparam logic [RW-1:0] FIRST = RW'(LEAD_BITS);

  logic [RW-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt <= '0;
      data <= '0;
    end else if (clear) begin
      rcnt <= '0;
    end else if (rise_tick) begin
      rcnt <= rcnt + 1'b1;
      if (rcnt >= FIRST)
        data <= {data[DATA_W-2:0], sdi};
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int FRAME_FALLS = 16,
  parameter int SHUT_FALLS  = 12,
  parameter int QUIET_CYC   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic low_power,
  input  logic fall_tick,
  input  logic rise_tick,
  output logic cs_active,
  output logic frame_open,
  output logic real_done
);
  localparam int FW = $clog2(FRAME_FALLS + 1);
  localparam int QW = (QUIET_CYC > 1) ? $clog2(QUIET_CYC) : 1;
  localparam logic [FW-1:0] FULL_LIM = FW'(FRAME_FALLS);
  localparam logic [FW-1:0] SHUT_LIM = FW'(SHUT_FALLS);
  localparam logic [QW-1:0] Q_LAST   = QW'(QUIET_CYC - 1);

  seq_state_t  state;
  frame_kind_t kind;
  logic [FW-1:0] fcnt;
  logic [QW-1:0] qcnt;
  logic need_wake;
  logic lp_hold;
  logic [FW-1:0] limit;
  logic frame_end;

  assign limit     = (kind == FR_SHUT) ? SHUT_LIM : FULL_LIM;
  assign frame_end = (state == ST_FRAME) && rise_tick && (fcnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      kind       <= FR_DUMMY;
      fcnt       <= '0;
      qcnt       <= '0;
      need_wake  <= 1'b1;
      lp_hold    <= 1'b0;
      cs_active  <= 1'b0;
      frame_open <= 1'b0;
      real_done  <= 1'b0;
    end else begin
      frame_open <= 1'b0;
      real_done  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_FRAME;
            kind       <= need_wake ? FR_DUMMY : FR_REAL;
            fcnt       <= '0;
            cs_active  <= 1'b1;
            frame_open <= 1'b1;
          end
        end
        ST_FRAME: begin
          if (fall_tick)
            fcnt <= fcnt + 1'b1;
          if (frame_end) begin
            state     <= ST_QUIET;
            qcnt      <= '0;
            cs_active <= 1'b0;
            unique case (kind)
              FR_DUMMY: need_wake <= 1'b0;
              FR_REAL: begin
                real_done <= 1'b1;
                lp_hold   <= low_power;
              end
              default:  need_wake <= 1'b1;
            endcase
          end
        end
        ST_QUIET: begin
          if (qcnt == Q_LAST) begin
            if (kind == FR_DUMMY || (kind == FR_REAL && lp_hold)) begin
              state      <= ST_FRAME;
              kind       <= (kind == FR_DUMMY) ? FR_REAL : FR_SHUT;
              fcnt       <= '0;
              cs_active  <= 1'b1;
              frame_open <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            qcnt <= qcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq #(
  parameter int DATA_W      = 12,
  parameter int LEAD_BITS   = 4,
  parameter int FRAME_FALLS = 16,
  parameter int SHUT_FALLS  = 12,
  parameter int HALF_DIV    = 4,
  parameter int QUIET_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              low_power_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] sample_o,
  output logic              valid_o
);
  logic cs_active;
  logic frame_open;
  logic real_done;
  logic fall_tick;
  logic rise_tick;
  logic [DATA_W-1:0] cap_data;

  adc_conv_seq #(
    .FRAME_FALLS(FRAME_FALLS),
    .SHUT_FALLS (SHUT_FALLS),
    .QUIET_CYC  (QUIET_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .low_power (low_power_i),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .cs_active (cs_active),
    .frame_open(frame_open),
    .real_done (real_done)
  );

  adc_sclk_gen #(
    .HALF_DIV(HALF_DIV)
  ) u_sclk (
    .clk      (clk),
    .rst      (rst),
    .run      (cs_active),
    .sclk     (sclk_o),
    .fall_tick(fall_tick),
    .rise_tick(rise_tick)
  );

  adc_capture #(
    .DATA_W     (DATA_W),
    .LEAD_BITS  (LEAD_BITS),
    .FRAME_FALLS(FRAME_FALLS)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clear    (frame_open),
    .rise_tick(rise_tick),
    .sdi      (sdi_i),
    .data     (cap_data)
  );

  assign cs_n_o = ~cs_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= real_done;
      if (real_done)
        sample_o <= cap_data;
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int FRAME_FALLS = 16,
  parameter int SHUT_FALLS  = 12,
  parameter int QUIET_CYC   = 8
) (
  input logic clk,
  input logic rst,
  input logic cs_n_o,
  input logic sclk_o,
  input logic valid_o
);
  localparam int FW = $clog2(FRAME_FALLS + 2);
  localparam int HW = $clog2(QUIET_CYC + 2);

  logic prev_cs;
  logic prev_sclk;
  logic [FW-1:0] falls;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cs   <= 1'b1;
      prev_sclk <= 1'b1;
      falls     <= '0;
      hi_cnt    <= HW'(QUIET_CYC);
    end else begin
      prev_cs   <= cs_n_o;
      prev_sclk <= sclk_o;
      if (!cs_n_o && prev_cs)
        falls <= '0;
      else if (!cs_n_o && prev_sclk && !sclk_o)
        falls <= falls + 1'b1;
      if (!cs_n_o)
        hi_cnt <= '0;
      else if (hi_cnt < HW'(QUIET_CYC))
        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (cs_n_o && sclk_o && !valid_o));

  // R2
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (rst) cs_n_o |-> sclk_o);

  // R7
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> (int'(falls) == FRAME_FALLS || int'(falls) == SHUT_FALLS));

  // R5
  quiet_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (int'(hi_cnt) >= QUIET_CYC));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst) valid_o |=> !valid_o);

  // R6
  valid_between_frames_chk: assert property (@(posedge clk) disable iff (rst) valid_o |-> cs_n_o);
endmodule

bind serial_adc_seq adc_seq_chk #(
  .FRAME_FALLS(FRAME_FALLS),
  .SHUT_FALLS (SHUT_FALLS),
  .QUIET_CYC  (QUIET_CYC)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_n_o (cs_n_o),
  .sclk_o (sclk_o),
  .valid_o(valid_o)
);

// File: tb/sim_serial_adc_seq.sv
module sim_serial_adc_seq;
  localparam int DATA_W = 12;
  localparam int LEAD   = 4;
  localparam int FULL   = 16;
  localparam int SHUT   = 12;
  localparam int HDIV   = 2;
  localparam int QUIET  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic low_power_i = 1'b0;
  logic cs_n_o;
  logic sclk_o;
  logic sdi_i = 1'b0;
  logic [DATA_W-1:0] sample_o;
  logic valid_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  serial_adc_seq #(
    .DATA_W(DATA_W), .LEAD_BITS(LEAD), .FRAME_FALLS(FULL),
    .SHUT_FALLS(SHUT), .HALF_DIV(HDIV), .QUIET_CYC(QUIET)
  ) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .low_power_i(low_power_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdi_i(sdi_i),
    .sample_o(sample_o), .valid_o(valid_o)
  );

  function automatic logic [DATA_W-1:0] wordval(input int i);
    case (i % 6)
      0: wordval = 12'h000;
      1: wordval = 12'hFFF;
      2: wordval = 12'h800;
      3: wordval = 12'h001;
      default: wordval = 12'((i * 2531 + 1171) * 7);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and port monitor
  logic prev_s = 1'b1, prev_c = 1'b1, prev_v = 1'b0;
  int frames = 0, cur_idx = 0, fcnt = 0, hi = 0, low_len = 0, cycles = 0;
  int valids = 0, last_vidx = -1;
  logic [DATA_W-1:0] last_data = '0;
  logic [15:0] cur_word = '0;
  int falls_log [0:63];

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (!rst) begin
      if (cs_n_o && !sclk_o) chk(1'b0, "R2 sclk idle", 0, 1);
      if (!cs_n_o && prev_c) begin
        if (frames > 0) chk(hi >= QUIET, "R5 quiet gap", hi, QUIET);
        cur_idx  = frames;
        frames++;
        fcnt     = 0;
        cur_word = {4'b1011, wordval(cur_idx)};
      end
      if (!cs_n_o && prev_s && !sclk_o) begin
        fcnt++;
        low_len = 0;
        if (fcnt >= 1 && fcnt <= 16) sdi_i <= cur_word[16 - fcnt];
      end
      if (!cs_n_o && !sclk_o) low_len++;
      if (!cs_n_o && !prev_s && sclk_o)
        chk(low_len == HDIV, "R2 low phase", low_len, HDIV);
      if (cs_n_o && !prev_c) falls_log[cur_idx % 64] = fcnt;
      hi = cs_n_o ? hi + 1 : 0;
      if (valid_o) begin
        if (prev_v) chk(1'b0, "R6 valid width", 2, 1);
        valids++;
        last_data = sample_o;
        last_vidx = cur_idx;
      end
    end
    prev_s = sclk_o;
    prev_c = cs_n_o;
    prev_v = valid_o;
  end

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 60) begin
      @(negedge clk);
      if (cs_n_o) q++; else q = 0;
    end
  endtask

  bit asleep = 1'b1;

  // one request; the dummy expectation follows R4/R8/R9, the shutdown tail R7
  task automatic run_op(input bit lp, input bit extra_starts);
    int f0 = frames;
    int v0 = valids;
    int nexp = int'(asleep) + 1 + int'(lp);
    int ridx = f0 + int'(asleep);
    low_power_i = lp;
    pulse_start();
    if (extra_starts) begin
      repeat (12) @(negedge clk);
      pulse_start();
      repeat (30) @(negedge clk);
      pulse_start();
    end
    wait_idle();
    if (extra_starts)
      chk(frames - f0 == nexp, "R10 ignored start frames", frames - f0, nexp);
    else if (asleep)
      chk(frames - f0 == nexp, "R4/R8 dummy first", frames - f0, nexp);
    else
      chk(frames - f0 == nexp, "R9 single frame", frames - f0, nexp);
    chk(valids - v0 == 1, "R6 one valid", valids - v0, 1);
    chk(last_data == wordval(ridx), "R3 sample value", int'(last_data), int'(wordval(ridx)));
    chk(last_vidx == ridx, "R4 dummy discarded", last_vidx, ridx);
    for (int f = f0; f < frames; f++) begin
      if (lp && f == frames - 1)
        chk(falls_log[f % 64] == SHUT, "R7 shutdown length", falls_log[f % 64], SHUT);
      else
        chk(falls_log[f % 64] == FULL, "R2 frame length", falls_log[f % 64], FULL);
    end
    asleep = lp;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1 cs_n", int'(cs_n_o), 1);
    chk(sclk_o == 1'b1, "R1 sclk", int'(sclk_o), 1);
    chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1 idle after reset", int'(cs_n_o), 1);
    run_op(1'b0, 1'b0);
    run_op(1'b0, 1'b0);
    run_op(1'b1, 1'b0);
    run_op(1'b1, 1'b0);
    run_op(1'b0, 1'b0);
    run_op(1'b0, 1'b1);
    run_op(1'b1, 1'b1);
    for (int k = 0; k < 24; k++)
      run_op((k % 3) == 2 || (k % 5) == 4, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule